// File: doc/BRIEF.md
# SPI Register Slave with Pipelined Replies

This block lets a host processor reach a small register map over a four-wire SPI link in clock mode 1. Each transfer is a 16-bit word framed by chip select. The block brings chip select, serial clock and data-in into its own system clock through two-flop synchronisers and finds the edges there. It shifts in the host's word and checks its even parity. When chip select goes high it carries out the command. The reply to a command goes out on MISO during the host's next frame. So a host that issues a chain of reads gets each answer one frame late.

The map holds two 14-bit configuration registers that the host can write, and which drive output ports. It also holds read-only views of a raw angle, a compensated angle and a diagnostic word, each taken from an input port. An error register collects parity, address and framing faults until the host reads it. The read clears it. The system clock must run at least four times faster than the serial clock.

Top module: `spi_regif`

## Requirements
- R1: MOSI is sampled on falling SCLK edges while CSn is low, most significant bit first. A frame begins when CSn falls with SCLK low and holds 16 bits.
- R2: A command word carries the register address in bits 13:0 and the direction in bit 14, where 1 means read and 0 means write. Bit 15 makes the count of ones across all 16 bits even.
- R3: A command is carried out when CSn rises. Its reply is shifted out on MISO, most significant bit first, during the next frame. The reply word holds data in bits 13:0 and an error flag in bit 14, and bit 15 gives it even parity over 16 bits. The error flag is 1 when the frame just carried out had any fault, and the data is then zero.
- R4: A write is a command frame followed by a data frame, whose payload sits in bits 13:0 with bit 14 at 0 and bit 15 giving even parity. The register's old content is returned during the data frame. The written value is returned in the frame after it. Address 0x0018 drives `cfg0_o` and address 0x0019 drives `cfg1_o`. Each output takes its new value three system clocks after CSn rises at the pin.
- R5: Address 0x0000 reads as zero. Address 0x3FFC returns `diag_i`, address 0x3FFE returns `angle_raw_i` and address 0x3FFF returns `angle_comp_i`.
- R6: A command frame or write data frame with odd parity is not carried out and changes no configuration register. It sets bit 2 of the error register.
- R7: A read of an unmapped address, or a write to any address other than 0x0018 and 0x0019, sets bit 1 of the error register. Such a write does not wait for a data frame.
- R8: A frame is discarded as a framing error, setting bit 0 of the error register and cancelling any pending write, in two cases. The first is a frame that ends after a bit count that is not a multiple of 16. The second is a frame with no bits at all.
- R9: The error register at address 0x0001 keeps each flag set until it is read. A read returns all flags gathered since the previous read and then clears them to zero.
- R10: After reset both configuration outputs are zero and the first reply word is 0x0000. MISO is low whenever CSn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn_i | input | 1 | Chip select, active low |
| spi_sclk_i | input | 1 | Serial clock from the host, idle low |
| spi_mosi_i | input | 1 | Serial data from the host |
| spi_miso_o | output | 1 | Serial reply data to the host |
| angle_raw_i | input | 14 | Uncompensated angle, read at 0x3FFE |
| angle_comp_i | input | 14 | Compensated angle, read at 0x3FFF |
| diag_i | input | 14 | Diagnostic word, read at 0x3FFC |
| cfg0_o | output | 14 | Configuration register at 0x0018 |
| cfg1_o | output | 14 | Configuration register at 0x0019 |

## Verification
Every pin goes through a two-stage synchroniser and then an edge register. So a command's effect on `cfg0_o` and `cfg1_o` lands on the third clock edge after CSn rises, and the bench samples these outputs eight clocks after the rise. The first reply bit is valid three clocks after CSn falls, and each later bit three clocks after the falling SCLK edge that moves it. The bench therefore holds each SCLK half-period for five clocks and reads MISO just before each falling edge. A reply is checked one frame after its command, matching the pipeline, and the write tests check both the old content returned during the data frame and the new content returned in the frame after it.

// File: rtl/spi_regif_pkg.sv
// Shared constants and helpers for the SPI register slave.
// Assumes 16-bit frames whose top two bits are parity and a flag.
package spi_regif_pkg;
    localparam int WORD_W = 16;
    localparam int DATA_W = WORD_W - 2;
    localparam int ERR_W  = 3;

    localparam logic [DATA_W-1:0] A_NOP  = 14'h0000;
    localparam logic [DATA_W-1:0] A_ERR  = 14'h0001;
    localparam logic [DATA_W-1:0] A_CFG0 = 14'h0018;
    localparam logic [DATA_W-1:0] A_CFG1 = 14'h0019;
    localparam logic [DATA_W-1:0] A_DIAG = 14'h3FFC;
    localparam logic [DATA_W-1:0] A_RAW  = 14'h3FFE;
    localparam logic [DATA_W-1:0] A_COMP = 14'h3FFF;

    // Error flag bit positions, as seen by the host
    localparam int E_FRAME = 0;
    localparam int E_ADDR  = 1;
    localparam int E_PAR   = 2;

    // Builds a reply word with even parity in the top bit
    function automatic logic [WORD_W-1:0] mk_word(input logic flag,
                                                  input logic [DATA_W-1:0] d);
        return {^{flag, d}, flag, d};
    endfunction
endpackage

// File: rtl/spi_regif_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives each bit its idle level.
module spi_regif_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift every pin one stage deeper each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_regif_frame.sv
// Serial framing: detects edges on the synchronised pins, shifts MOSI in on
// falling SCLK, shifts the reply out, and flags frame end and framing state.
// Assumes SCLK is low when CSn falls and the system clock is >= 4x SCLK.
module spi_regif_frame
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] reply_i,
    output logic              miso_o,
    output logic              frame_end_o,
    output logic              frame_ok_o,
    output logic [WORD_W-1:0] rx_word_o
);
    localparam int CNT_W = $clog2(WORD_W);

    logic              csn_q, sclk_q;
    logic              cs_start, cs_stop, sclk_fall;
    logic [WORD_W-1:0] rx_shift, tx_shift;
    logic [CNT_W-1:0]  bit_cnt;
    logic              got_word;

    assign cs_start  = csn_q & ~csn_s;
    assign cs_stop   = ~csn_q & csn_s;
    assign sclk_fall = sclk_q & ~sclk_s & ~csn_s;

    // Keep previous pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csn_q  <= csn_s;
            sclk_q <= sclk_s;
        end
    end

    // Load the reply at frame start, then shift both directions per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_shift  <= '0;
            tx_shift  <= '0;
            bit_cnt   <= '0;
            got_word  <= 1'b0;
            rx_word_o <= '0;
        end else if (cs_start) begin
            tx_shift <= reply_i;
            bit_cnt  <= '0;
            got_word <= 1'b0;
        end else if (sclk_fall) begin
            rx_shift <= {rx_shift[WORD_W-2:0], mosi_s};
            tx_shift <= {tx_shift[WORD_W-2:0], 1'b0};
            bit_cnt  <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                got_word  <= 1'b1;
                rx_word_o <= {rx_shift[WORD_W-2:0], mosi_s};
            end
        end
    end

    assign frame_end_o = cs_stop;
    assign frame_ok_o  = got_word && (bit_cnt == '0);
    assign miso_o      = ~csn_s & tx_shift[WORD_W-1];
endmodule

// File: rtl/spi_regif_regs.sv
// Command execution and register map: decodes the received word at frame
// end, handles the two-frame write, keeps sticky error flags and the reply.
// Assumes frame_end_i is a one-cycle pulse.
module spi_regif_regs
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic              frame_ok_i,
    input  logic [WORD_W-1:0] rx_word_i,
    input  logic [DATA_W-1:0] angle_raw_i,
    input  logic [DATA_W-1:0] angle_comp_i,
    input  logic [DATA_W-1:0] diag_i,
    output logic [WORD_W-1:0] reply_o,
    output logic [DATA_W-1:0] cfg0_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [ERR_W-1:0]  err_flags_o,
    output logic              err_clr_o
);
    logic              par_ok, is_read, rd_valid, wr_ok;
    logic [DATA_W-1:0] addr, rd_data;
    logic              pend, pend_nxt;
    logic [DATA_W-1:0] pend_addr;
    logic [ERR_W-1:0]  err_set;
    logic              wr0, wr1;
    logic [WORD_W-1:0] reply_nxt;

    assign par_ok  = ~^rx_word_i;
    assign is_read = rx_word_i[WORD_W-2];
    assign addr    = rx_word_i[DATA_W-1:0];
    assign wr_ok   = (addr == A_CFG0) || (addr == A_CFG1);

    // Read multiplexer over the register map
    always_comb begin
        rd_valid = 1'b1;
        rd_data  = '0;
        case (addr)
            A_NOP:   rd_data = '0;
            A_ERR:   rd_data = DATA_W'(err_flags_o);
            A_CFG0:  rd_data = cfg0_o;
            A_CFG1:  rd_data = cfg1_o;
            A_DIAG:  rd_data = diag_i;
            A_RAW:   rd_data = angle_raw_i;
            A_COMP:  rd_data = angle_comp_i;
            default: rd_valid = 1'b0;
        endcase
    end

    // Decide the effect of the frame that just ended
    always_comb begin
        err_set   = '0;
        err_clr_o = 1'b0;
        wr0       = 1'b0;
        wr1       = 1'b0;
        pend_nxt  = pend;
        reply_nxt = reply_o;
        if (frame_end_i) begin
            pend_nxt  = 1'b0;
            reply_nxt = mk_word(1'b1, '0);
            if (!frame_ok_i) begin
                err_set[E_FRAME] = 1'b1;
            end else if (!par_ok) begin
                err_set[E_PAR] = 1'b1;
            end else if (pend) begin
                wr0       = (pend_addr == A_CFG0);
                wr1       = (pend_addr == A_CFG1);
                reply_nxt = mk_word(1'b0, addr);
            end else if (is_read) begin
                if (rd_valid) begin
                    reply_nxt = mk_word(1'b0, rd_data);
                    err_clr_o = (addr == A_ERR);
                end else begin
                    err_set[E_ADDR] = 1'b1;
                end
            end else if (wr_ok) begin
                pend_nxt  = 1'b1;
                reply_nxt = mk_word(1'b0, rd_data);
            end else begin
                err_set[E_ADDR] = 1'b1;
            end
        end
    end

    // Commit state: errors, pending write, configuration and reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flags_o <= '0;
            pend        <= 1'b0;
            pend_addr   <= '0;
            cfg0_o      <= '0;
            cfg1_o      <= '0;
            reply_o     <= '0;
        end else begin
            err_flags_o <= (err_clr_o ? '0 : err_flags_o) | err_set;
            pend        <= pend_nxt;
            reply_o     <= reply_nxt;
            if (frame_end_i && !pend) pend_addr <= addr;
            if (wr0) cfg0_o <= addr;
            if (wr1) cfg1_o <= addr;
        end
    end
endmodule

// File: rtl/spi_regif.sv
// Top level of the SPI register slave: synchronises the pins, frames the
// serial words and executes commands against the register map.
// Assumes the system clock runs at least four times the SCLK rate.
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn_i,
    input  logic              spi_sclk_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    input  logic [DATA_W-1:0] angle_raw_i,
    input  logic [DATA_W-1:0] angle_comp_i,
    input  logic [DATA_W-1:0] diag_i,
    output logic [DATA_W-1:0] cfg0_o,
    output logic [DATA_W-1:0] cfg1_o
);
    logic [2:0]        pins_s;
    logic              frame_end, frame_ok;
    logic [WORD_W-1:0] rx_word, reply;
    logic [ERR_W-1:0]  err_flags;
    logic              err_clr;

    spi_regif_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_mosi_i, spi_sclk_i, spi_csn_i}),
        .q_o   (pins_s)
    );

    spi_regif_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_s       (pins_s[0]),
        .sclk_s      (pins_s[1]),
        .mosi_s      (pins_s[2]),
        .reply_i     (reply),
        .miso_o      (spi_miso_o),
        .frame_end_o (frame_end),
        .frame_ok_o  (frame_ok),
        .rx_word_o   (rx_word)
    );

    spi_regif_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end_i  (frame_end),
        .frame_ok_i   (frame_ok),
        .rx_word_i    (rx_word),
        .angle_raw_i  (angle_raw_i),
        .angle_comp_i (angle_comp_i),
        .diag_i       (diag_i),
        .reply_o      (reply),
        .cfg0_o       (cfg0_o),
        .cfg1_o       (cfg1_o),
        .err_flags_o  (err_flags),
        .err_clr_o    (err_clr)
    );
endmodule

// File: rtl/spi_regif_chk.sv
// Assertion checker for the SPI register slave, bound into the top.
module spi_regif_chk
    import spi_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic [ERR_W-1:0]  err_flags,
    input logic              err_clr,
    input logic [DATA_W-1:0] cfg0,
    input logic [DATA_W-1:0] cfg1
);
    // R4: configuration only changes on the cycle after a frame end
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(cfg0) && $stable(cfg1)));

    // R9: without a clearing read, no error flag ever drops
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R9: a clearing read leaves the register empty
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_flags == '0));

    // R3: clearing only happens as part of executing a frame
    a_r3_clr_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |-> frame_end);
endmodule

bind spi_regif spi_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .err_flags (err_flags),
    .err_clr   (err_clr),
    .cfg0      (cfg0_o),
    .cfg1      (cfg1_o)
);

// File: tb/spi_regif_bench.sv
`timescale 1ns/1ps
module spi_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso;
    logic [13:0] cfg0, cfg1;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] got;

    localparam int HALF = 5;
    localparam logic [13:0] RAW  = 14'h1234;
    localparam logic [13:0] COMP = 14'h2ABC;
    localparam logic [13:0] DIAG = 14'h0180;

    always #2.5 clk = ~clk;

    spi_regif u_spi_regif (
        .clk(clk), .rst_n(rst_n), .spi_csn_i(csn), .spi_sclk_i(sclk),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .angle_raw_i(RAW),
        .angle_comp_i(COMP), .diag_i(DIAG), .cfg0_o(cfg0), .cfg1_o(cfg1)
    );

    function automatic logic [15:0] cmd(input logic rd, input logic [13:0] a);
        return {^{rd, a}, rd, a};
    endfunction
    function automatic logic [15:0] rsp(input logic ef, input logic [13:0] d);
        return {^{ef, d}, ef, d};
    endfunction

    // {MOSI word, expected MISO word in that frame, requirement number}
    localparam int NV = 17;
    localparam logic [39:0] VEC [NV] = '{
        {cmd(1, 14'h3FFE), 16'h0000,          8'd10}, // R10 first reply
        {cmd(1, 14'h3FFF), rsp(0, RAW),       8'd5},  // R5 raw angle
        {cmd(1, 14'h3FFC), rsp(0, COMP),      8'd5},  // R5 comp angle
        {cmd(0, 14'h0018), rsp(0, DIAG),      8'd5},  // R5 diagnostics
        {cmd(0, 14'h0155), rsp(0, 14'h0),     8'd4},  // R4 old content
        {cmd(1, 14'h0000), rsp(0, 14'h0155),  8'd4},  // R4 new content
        {cmd(1, 14'h0018), rsp(0, 14'h0),     8'd5},  // R5 nop reads zero
        {cmd(1, 14'h3FFE) ^ 16'h8000, rsp(0, 14'h0155), 8'd2}, // R2 readback
        {cmd(1, 14'h0001), rsp(1, 14'h0),     8'd6},  // R6 error flag
        {cmd(1, 14'h0001), rsp(0, 14'h0004),  8'd6},  // R6 parity bit
        {cmd(1, 14'h1234), rsp(0, 14'h0),     8'd9},  // R9 cleared
        {cmd(1, 14'h0001), rsp(1, 14'h0),     8'd7},  // R7 flag
        {cmd(1, 14'h0000), rsp(0, 14'h0002),  8'd7},  // R7 addr bit
        {cmd(0, 14'h3FFE), rsp(0, 14'h0),     8'd3},  // R3 nop reply
        {cmd(1, 14'h0001), rsp(1, 14'h0),     8'd7},  // R7 write to RO
        {cmd(1, 14'h0019), rsp(0, 14'h0002),  8'd7},  // R7 flag held
        {cmd(1, 14'h0000), rsp(0, 14'h0),     8'd10}  // R10 cfg1 reset
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    // One frame: R1 mode 1, MSB first, MISO read just before each fall
    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
        r = '0;
        csn = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            mosi = w[15-i];
            sclk = 1'b1;
            wait_clk(HALF);
            r = {r[14:0], miso};
            sclk = 1'b0;
            wait_clk(HALF);
        end
        wait_clk(4);
        csn = 1'b1;
        wait_clk(8);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        check(10, {15'b0, miso}, 16'h0);     // R10 idle MISO after reset
        check(10, {2'b0, cfg0}, 16'h0);      // R10 cfg0 reset
        check(10, {2'b0, cfg1}, 16'h0);      // R10 cfg1 reset

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][39:24], 16, got);
            check(int'(VEC[i][7:0]), got, VEC[i][23:8]);
            if (i == 4) check(4, {2'b0, cfg0}, 16'h0155); // R4 cfg0 written
        end
        check(10, {15'b0, miso}, 16'h0);     // R10 MISO low between frames

        // R4: write cfg1 and see old and new content
        xfer(cmd(0, 14'h0019), 16, got);
        xfer(cmd(0, 14'h2AAA), 16, got);
        check(4, got, rsp(0, 14'h0));
        check(4, {2'b0, cfg1}, 16'h2AAA);
        // R6: bad parity on a write data frame
        xfer(cmd(0, 14'h0019), 16, got);
        check(4, got, rsp(0, 14'h2AAA));
        xfer(cmd(0, 14'h1111) ^ 16'h8000, 16, got);
        check(6, {2'b0, cfg1}, 16'h2AAA);
        xfer(cmd(1, 14'h0001), 16, got);
        check(6, got, rsp(1, 14'h0));
        xfer(cmd(1, 14'h0000), 16, got);
        check(6, got, rsp(0, 14'h0004));
        // R8: short frame is discarded and flagged
        xfer(cmd(1, 14'h3FFE), 8, got);
        xfer(cmd(1, 14'h0001), 16, got);
        check(8, got, rsp(1, 14'h0));
        xfer(cmd(1, 14'h0000), 16, got);
        check(8, got, rsp(0, 14'h0001));
        // R9: flags accumulate, then one read clears them
        xfer(cmd(1, 14'h0100), 16, got);
        xfer(cmd(1, 14'h0000) ^ 16'h8000, 16, got);
        xfer(cmd(1, 14'h0001), 16, got);
        check(9, got, rsp(1, 14'h0));
        xfer(cmd(1, 14'h0001), 16, got);
        check(9, got, rsp(0, 14'h0006));
        xfer(cmd(1, 14'h0000), 16, got);
        check(9, got, rsp(0, 14'h0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule